// File: doc/BRIEF.md
# Multi-Level Priority Interrupt Controller

This controller gathers interrupt requests that are grouped into a fixed number of priority levels, each level holding a pending mask of up to 64 sources. A single command port posts or clears one source bit, or wipes every level at once. Alongside each mask the block keeps a one-bit-per-level status vector that shows which levels have anything pending.

The priority resolver merges two sources: the registered status levels that fall in an external range, and a software request vector scanned over its own range. It produces a combined summary vector and a winning priority. That priority is compared against the core's current priority level. A request goes to the core only when something is pending, the core is interruptible (the two low PC bits are zero), and the winner is strictly higher. When the core acknowledges, the summary and the winning priority are captured into two read registers. A nonzero asynchronous-trap request is not supported and is flagged. A malformed post or clear is flagged and dropped.

Top module: `irq_ctrl_top`

## Requirements
- R1: A command with cmd_op = 2'b01 (post), an in-range level L and an in-range index K sets bit K of level L's pending mask and sets status bit L, visible after the next rising clock edge.
- R2: A command with cmd_op = 2'b10 (clear) resets bit K of level L's mask. Status bit L drops only when that level's mask becomes all zero, and stays set while any other bit of the level is pending.
- R3: A command with cmd_op = 2'b11 (clear-all) zeroes every pending mask and the whole status vector at the next edge, whatever cmd_level and cmd_index hold.
- R4: irq is asserted only while the status vector is nonzero and pc_low equals 2'b00.
- R5: Each set bit i of sw_req with SW_MIN <= i < SW_MAX gives the candidate priority (i - SW_MIN) + 1 and sets bit i of the summary. The highest such i wins among software bits, and sw_req bits outside that range are ignored.
- R6: Each set status bit i with EXT_MIN <= i < EXT_MAX sets summary bit i. The highest such i sets the priority to i, and it overrides any software priority.
- R7: irq requires the resolved priority to be nonzero and strictly greater than cur_ipl. Equal or lower gives no request.
- R8: When ack is high while irq is high at a rising edge, isr takes the summary and intid takes the priority at that edge. An ack without irq leaves both unchanged.
- R9: trap_err is high whenever async_trap is nonzero, and low otherwise.
- R10: A post or clear whose level is not below NUM_LEVELS, or whose index is not below SRC_PER_LVL, raises cmd_err in the same cycle and changes no mask or status bit.
- R11: Reset leaves every mask, the status vector, isr and intid at zero and irq low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 01 post, 10 clear, 11 clear-all, 00 none |
| cmd_level | input | CMD_W | Target priority level |
| cmd_index | input | CMD_W | Target source index within the level |
| sw_req | input | NUM_LEVELS | Software interrupt request vector |
| async_trap | input | TRAP_W | Asynchronous-trap request value (unsupported) |
| pc_low | input | 2 | Low two bits of the current PC |
| cur_ipl | input | PW | Current priority level of the core |
| ack | input | 1 | Core acknowledge of the request |
| irq | output | 1 | Interrupt request to the core |
| status | output | NUM_LEVELS | Per-level pending summary |
| isr | output | NUM_LEVELS | Captured summary vector |
| intid | output | PW | Captured winning priority |
| cmd_err | output | 1 | Malformed post or clear this cycle |
| trap_err | output | 1 | Asynchronous trap requested |

## Verification
Every one of the 256 status patterns of an eight-level configuration is built from posts. Each pattern is crossed with eight software request patterns, every current priority and every PC low-bit value. This separates external-over-software ordering, the strict-greater threshold and PC masking. Source-by-source post and clear walks through every level tell whether a status bit falls too early or too late. Sweeps of out-of-range levels and indices, trap values, and acks with no request pending show that these are flagged or ignored without disturbing state.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  typedef enum logic [1:0] {
    OP_NONE   = 2'b00,
    OP_POST   = 2'b01,
    OP_CLEAR  = 2'b10,
    OP_CLRALL = 2'b11
  } irq_op_e;
endpackage

// File: rtl/irq_pending_bank.sv
module irq_pending_bank
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_LEVELS  = 32,
  parameter int SRC_PER_LVL = 64,
  parameter int CMD_W       = 8,
  localparam int IDXW       = $clog2(SRC_PER_LVL)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              cmd_valid,
  input  logic [1:0]                        cmd_op,
  input  logic [CMD_W-1:0]                  cmd_level,
  input  logic [CMD_W-1:0]                  cmd_index,
  output logic [NUM_LEVELS*SRC_PER_LVL-1:0] mask_flat,
  output logic [NUM_LEVELS-1:0]             status_q,
  output logic                              cmd_err
);
  localparam logic [CMD_W:0] LVL_LIM = (CMD_W+1)'(NUM_LEVELS);
  localparam logic [CMD_W:0] IDX_LIM = (CMD_W+1)'(SRC_PER_LVL);

  logic                   in_range, do_post, do_clear, do_all;
  logic [SRC_PER_LVL-1:0] idx_oh;

  always_comb begin
    in_range = ({1'b0, cmd_level} < LVL_LIM) && ({1'b0, cmd_index} < IDX_LIM);
    do_post  = cmd_valid && (cmd_op == OP_POST)   && in_range;
    do_clear = cmd_valid && (cmd_op == OP_CLEAR)  && in_range;
    do_all   = cmd_valid && (cmd_op == OP_CLRALL);
    cmd_err  = cmd_valid && ((cmd_op == OP_POST) || (cmd_op == OP_CLEAR)) && !in_range;
    idx_oh   = SRC_PER_LVL'(1) << cmd_index[IDXW-1:0];
  end

  for (genvar l = 0; l < NUM_LEVELS; l++) begin : g_lvl
    logic                   hit, en;
    logic                   st_d;
    logic [SRC_PER_LVL-1:0] mask_q, mask_d;

    always_comb begin
      hit    = (cmd_level == CMD_W'(l));
      en     = do_all || ((do_post || do_clear) && hit);
      mask_d = mask_q;
      st_d   = status_q[l];
      if (do_all) begin
        mask_d = '0;
        st_d   = 1'b0;
      end else if (do_post) begin
        mask_d = mask_q | idx_oh;
        st_d   = 1'b1;
      end else if (do_clear) begin
        mask_d = mask_q & ~idx_oh;
        st_d   = |(mask_q & ~idx_oh);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask_q      <= '0;
        status_q[l] <= 1'b0;
      end else if (en) begin
        mask_q      <= mask_d;
        status_q[l] <= st_d;
      end
    end

    assign mask_flat[l*SRC_PER_LVL +: SRC_PER_LVL] = mask_q;
  end
endmodule

// File: rtl/irq_prio_resolve.sv
module irq_prio_resolve #(
  parameter int NUM_LEVELS = 32,
  parameter int SW_MIN     = 1,
  parameter int SW_MAX     = 16,
  parameter int EXT_MIN    = 16,
  parameter int EXT_MAX    = 31,
  localparam int PW        = $clog2(NUM_LEVELS)
) (
  input  logic [NUM_LEVELS-1:0] status,
  input  logic [NUM_LEVELS-1:0] sw_req,
  input  logic [1:0]            pc_low,
  input  logic [PW-1:0]         cur_ipl,
  output logic [NUM_LEVELS-1:0] summary,
  output logic [PW-1:0]         win_ipl,
  output logic                  irq
);
  always_comb begin
    summary = '0;
    win_ipl = '0;
    for (int i = SW_MIN; i < SW_MAX; i++) begin
      if (sw_req[i]) begin
        win_ipl    = PW'(i - SW_MIN + 1);
        summary[i] = 1'b1;
      end
    end
    for (int i = EXT_MIN; i < EXT_MAX; i++) begin
      if (status[i]) begin
        win_ipl    = PW'(i);
        summary[i] = 1'b1;
      end
    end
    irq = (|status) && (pc_low == 2'b00) && (win_ipl != '0) && (win_ipl > cur_ipl);
  end
endmodule

// File: rtl/irq_capture.sv
module irq_capture #(
  parameter int NUM_LEVELS = 32,
  localparam int PW        = $clog2(NUM_LEVELS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  take,
  input  logic [NUM_LEVELS-1:0] summary,
  input  logic [PW-1:0]         win_ipl,
  output logic [NUM_LEVELS-1:0] isr_q,
  output logic [PW-1:0]         intid_q
);
  logic [NUM_LEVELS-1:0] isr_d;
  logic [PW-1:0]         intid_d;

  always_comb begin
    isr_d   = take ? summary : isr_q;
    intid_d = take ? win_ipl : intid_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q   <= '0;
      intid_q <= '0;
    end else if (take) begin
      isr_q   <= isr_d;
      intid_q <= intid_d;
    end
  end
endmodule

// File: rtl/irq_ctrl_top.sv
module irq_ctrl_top #(
  parameter int NUM_LEVELS  = 32,
  parameter int SRC_PER_LVL = 64,
  parameter int CMD_W       = 8,
  parameter int TRAP_W      = 4,
  parameter int SW_MIN      = 1,
  parameter int SW_MAX      = 16,
  parameter int EXT_MIN     = 16,
  parameter int EXT_MAX     = 31,
  localparam int PW         = $clog2(NUM_LEVELS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_valid,
  input  logic [1:0]            cmd_op,
  input  logic [CMD_W-1:0]      cmd_level,
  input  logic [CMD_W-1:0]      cmd_index,
  input  logic [NUM_LEVELS-1:0] sw_req,
  input  logic [TRAP_W-1:0]     async_trap,
  input  logic [1:0]            pc_low,
  input  logic [PW-1:0]         cur_ipl,
  input  logic                  ack,
  output logic                  irq,
  output logic [NUM_LEVELS-1:0] status,
  output logic [NUM_LEVELS-1:0] isr,
  output logic [PW-1:0]         intid,
  output logic                  cmd_err,
  output logic                  trap_err
);
  logic [1:0]                        rst_pipe;
  logic                              rst_sync_n;
  logic [NUM_LEVELS*SRC_PER_LVL-1:0] pend_mask;
  logic [NUM_LEVELS-1:0]             summary;
  logic [PW-1:0]                     win_ipl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  irq_pending_bank #(
    .NUM_LEVELS(NUM_LEVELS), .SRC_PER_LVL(SRC_PER_LVL), .CMD_W(CMD_W)
  ) u_bank (
    .clk(clk), .rst_n(rst_sync_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_level(cmd_level), .cmd_index(cmd_index), .mask_flat(pend_mask),
    .status_q(status), .cmd_err(cmd_err)
  );

  irq_prio_resolve #(
    .NUM_LEVELS(NUM_LEVELS), .SW_MIN(SW_MIN), .SW_MAX(SW_MAX),
    .EXT_MIN(EXT_MIN), .EXT_MAX(EXT_MAX)
  ) u_res (
    .status(status), .sw_req(sw_req), .pc_low(pc_low), .cur_ipl(cur_ipl),
    .summary(summary), .win_ipl(win_ipl), .irq(irq)
  );

  irq_capture #(.NUM_LEVELS(NUM_LEVELS)) u_cap (
    .clk(clk), .rst_n(rst_sync_n), .take(ack && irq), .summary(summary),
    .win_ipl(win_ipl), .isr_q(isr), .intid_q(intid)
  );

  assign trap_err = |async_trap;
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int NUM_LEVELS  = 32,
  parameter int SRC_PER_LVL = 64,
  parameter int CMD_W       = 8,
  localparam int PW         = $clog2(NUM_LEVELS)
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic                              cmd_valid,
  input logic [1:0]                        cmd_op,
  input logic [CMD_W-1:0]                  cmd_level,
  input logic [1:0]                        pc_low,
  input logic [PW-1:0]                     cur_ipl,
  input logic                              ack,
  input logic                              irq,
  input logic [NUM_LEVELS-1:0]             status,
  input logic [NUM_LEVELS-1:0]             isr,
  input logic [PW-1:0]                     intid,
  input logic                              cmd_err,
  input logic [NUM_LEVELS*SRC_PER_LVL-1:0] pend_mask
);
  logic [NUM_LEVELS-1:0] lvl_any;
  always_comb begin
    for (int l = 0; l < NUM_LEVELS; l++)
      lvl_any[l] = |pend_mask[l*SRC_PER_LVL +: SRC_PER_LVL];
  end

  // R2: a status bit is set exactly when its level has a pending source
  p_status_tracks_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    status == lvl_any);

  // R1: a good post raises the addressed level's status bit
  p_post_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'b01 && !cmd_err && {1'b0, cmd_level} < (CMD_W+1)'(NUM_LEVELS))
      |=> status[$past(cmd_level)]);

  // R3: clear-all empties everything
  p_clrall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'b11) |=> (status == '0 && pend_mask == '0));

  // R4: no request with privileged PC or nothing pending
  p_irq_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (pc_low == 2'b00 && status != '0));

  // R7: a captured priority is above the level it was compared against
  p_capture_above_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq) |=> (intid > $past(cur_ipl)));

  // R8: captured registers hold without an accepted acknowledge
  p_ack_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack && irq) |=> ($stable(isr) && $stable(intid)));

  // R10: a malformed command leaves all state alone
  p_bad_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |=> ($stable(status) && $stable(pend_mask)));
endmodule

bind irq_ctrl_top irq_ctrl_chk #(
  .NUM_LEVELS(NUM_LEVELS), .SRC_PER_LVL(SRC_PER_LVL), .CMD_W(CMD_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_level(cmd_level), .pc_low(pc_low), .cur_ipl(cur_ipl), .ack(ack),
  .irq(irq), .status(status), .isr(isr), .intid(intid), .cmd_err(cmd_err),
  .pend_mask(pend_mask)
);

// File: tb/sim_irq_ctrl_top.sv
module sim_irq_ctrl_top;
  localparam int NL = 8, NS = 8, CW = 4, TW = 4, PW = 3;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          cmd_valid = 1'b0, ack = 1'b0;
  logic [1:0]    cmd_op = 2'b00, pc_low = 2'b00;
  logic [CW-1:0] cmd_level = '0, cmd_index = '0;
  logic [NL-1:0] sw_req = '0;
  logic [TW-1:0] async_trap = '0;
  logic [PW-1:0] cur_ipl = '0;
  logic          irq, cmd_err, trap_err;
  logic [NL-1:0] status, isr;
  logic [PW-1:0] intid;

  int nvec = 0, nerr = 0;
  logic [NS-1:0] mdl [NL];
  logic [NL-1:0] e_isr;
  logic [PW-1:0] e_id;

  always #2 clk = ~clk;

  irq_ctrl_top #(.NUM_LEVELS(NL), .SRC_PER_LVL(NS), .CMD_W(CW), .TRAP_W(TW),
                 .SW_MIN(1), .SW_MAX(4), .EXT_MIN(4), .EXT_MAX(8)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_level(cmd_level), .cmd_index(cmd_index), .sw_req(sw_req),
    .async_trap(async_trap), .pc_low(pc_low), .cur_ipl(cur_ipl), .ack(ack),
    .irq(irq), .status(status), .isr(isr), .intid(intid),
    .cmd_err(cmd_err), .trap_err(trap_err));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [NL-1:0] mdl_status();
    logic [NL-1:0] s;
    for (int l = 0; l < NL; l++) s[l] = |mdl[l];
    return s;
  endfunction

  task automatic cmd(input logic [1:0] op, input int lvl, input int idx);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_level = CW'(lvl); cmd_index = CW'(idx);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'b00;
    if (lvl < NL && idx < NS) begin
      if (op == 2'b01) mdl[lvl][idx] = 1'b1;
      if (op == 2'b10) mdl[lvl][idx] = 1'b0;
    end
    if (op == 2'b11) for (int l = 0; l < NL; l++) mdl[l] = '0;
  endtask

  // expected resolution from R5/R6
  task automatic resolve(input logic [NL-1:0] st, input logic [NL-1:0] sw,
                         output logic [NL-1:0] sum, output int ipl);
    sum = '0; ipl = 0;
    for (int i = 1; i < 4; i++) if (sw[i]) begin ipl = i; sum[i] = 1'b1; end
    for (int i = 4; i < 8; i++) if (st[i]) begin ipl = i; sum[i] = 1'b1; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    for (int l = 0; l < NL; l++) mdl[l] = '0;
    e_isr = '0; e_id = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R11 reset state
    chk(status == '0, "R11 status", 32'(status), 0);
    chk(isr == '0, "R11 isr", 32'(isr), 0);
    chk(intid == '0, "R11 intid", 32'(intid), 0);
    chk(irq == 1'b0, "R11 irq", 32'(irq), 0);

    // R1 / R2 walk: post every source, then clear every source
    for (int l = 0; l < NL; l++)
      for (int k = 0; k < NS; k++) begin
        cmd(2'b01, l, k);
        chk(status == mdl_status(), "R1 post", 32'(status), 32'(mdl_status()));
      end
    for (int l = 0; l < NL; l++)
      for (int k = 0; k < NS; k++) begin
        cmd(2'b10, l, k);
        chk(status == mdl_status(), "R2 clear", 32'(status), 32'(mdl_status()));
      end
    cmd(2'b10, 5, 3);
    chk(status == '0, "R2 clear idle", 32'(status), 0);
    cmd(2'b01, 6, 1); cmd(2'b01, 6, 6); cmd(2'b10, 6, 6);
    chk(status[6] == 1'b1, "R2 partial", 32'(status), 32'(mdl_status()));

    // R10 out-of-range levels and indices
    for (int v = 8; v < 16; v++) begin
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 2'b10; cmd_level = CW'(v); cmd_index = CW'(1);
      #1 chk(cmd_err == 1'b1, "R10 level err", 32'(cmd_err), 1);
      @(negedge clk);
      cmd_op = 2'b10; cmd_level = CW'(6); cmd_index = CW'(v);
      #1 chk(cmd_err == 1'b1, "R10 index err", 32'(cmd_err), 1);
      @(negedge clk);
      cmd_valid = 1'b0;
      chk(status == mdl_status(), "R10 no change", 32'(status), 32'(mdl_status()));
    end
    cmd(2'b01, 9, 0); cmd(2'b01, 2, 12);
    chk(status == mdl_status(), "R10 post ignored", 32'(status), 32'(mdl_status()));

    // R3 clear-all with junk level/index
    cmd(2'b01, 1, 2); cmd(2'b01, 7, 7);
    cmd(2'b11, 13, 11);
    chk(status == '0, "R3 clear-all", 32'(status), 0);

    // R9 trap flag
    for (int t = 0; t < 16; t++) begin
      async_trap = TW'(t);
      #1 chk(trap_err == (t != 0), "R9 trap", 32'(trap_err), 32'(t != 0));
    end
    async_trap = '0;

    // R4..R8 sweep over all status patterns
    for (int pat = 0; pat < 256; pat++) begin
      cmd(2'b11, 0, 0);
      for (int l = 0; l < NL; l++) if (pat[l]) cmd(2'b01, l, l);
      chk(status == NL'(pat), "R1 pattern", 32'(status), 32'(pat));
      for (int s = 0; s < 8; s++) begin
        logic [NL-1:0] swv, sum;
        int ipl;
        bit exp_irq;
        swv = NL'(s << 1) | ((s == 7) ? 8'h81 : 8'h00);
        resolve(NL'(pat), swv, sum, ipl);
        sw_req = swv;
        for (int c = 0; c < 8; c++)
          for (int p = 0; p < 4; p++) begin
            cur_ipl = PW'(c); pc_low = 2'(p);
            exp_irq = (pat != 0) && (p == 0) && (ipl != 0) && (ipl > c);
            #1 chk(irq == exp_irq, "R4 R5 R6 R7 irq", 32'(irq), 32'(exp_irq));
          end
        @(negedge clk);
        cur_ipl = '0; pc_low = 2'b00; ack = 1'b1;
        exp_irq = (pat != 0) && (ipl != 0);
        if (exp_irq) begin e_isr = sum; e_id = PW'(ipl); end
        @(negedge clk);
        ack = 1'b0;
        chk(isr == e_isr, "R8 R5 R6 isr", 32'(isr), 32'(e_isr));
        chk(intid == e_id, "R8 intid", 32'(intid), 32'(e_id));
      end
      sw_req = '0;
    end

    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule